// File: doc/BRIEF.md
# Serial Clock-Calendar and NVRAM Slave

This block sits behind three software-controlled register bits (a chip select, a serial clock and a bidirectional data bit) and answers a simple 16-bit serial protocol. Each framed transfer carries an 8-bit command first and then 8 data bits, most significant bit first. A bit is taken on each falling edge of the serial clock while the select is high. The command byte picks the target by its value: a 32-byte scratch memory, a status byte, or a bank of calendar registers. The calendar registers present externally supplied time counters in packed decimal form.

For read commands, the slave drives the data bit during the eight data phases. The register view of the data bit then shows the slave's value instead of the host's. Writes take effect only once the full 16 bits have arrived. Dropping the select at any point abandons the transfer. Writing the status byte with its clear key removes two status flags and sends a one-cycle pulse that clears an interrupt-status bit kept elsewhere.

Top module: `serial_rtc_slave`

## Requirements
- R1: After reset the status byte reads 0x90, every memory byte reads 0x00, the slave does not drive data and the clear pulse is low.
- R2: A bit is taken only on a high-to-low change of the serial clock seen while select is high; clock changes while select is low leave the next transfer unaffected.
- R3: Lowering select clears the edge count, the command and the data, so a write abandoned before its 16th edge changes nothing.
- R4: Commands 0x00 to 0x1F read memory byte [command]. After the 8th falling edge the MSB is on the data-out line, and each later edge moves to the next lower bit. Driving stops after the 16th edge.
- R5: Commands 0x80 to 0x9F store the 8 data bits into memory byte [command − 0x80] at the 16th falling edge.
- R6: Command 0x30 reads the status byte, and command 0x31 reads 0x00.
- R7: Commands 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 read seconds, minutes, hours, day of month, month and two-digit year. Each value is packed decimal, with the tens digit in bits 7:4 and the units digit in bits 3:0. The other commands from 0x20 to 0x2F read 0x00.
- R8: Command 0xB1 with data bit 2 set clears status bits 4 and 3 and raises the clear pulse for exactly one cycle. With bit 2 clear, it has no effect.
- R9: Falling edges after the 16th are ignored until select is lowered and raised again.
- R10: The data view output equals the slave's driven bit while the slave drives, and equals the host's data bit otherwise.
- R11: Commands outside the ranges above store nothing and drive nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | Transfer select from the control register |
| sclk_i | input | 1 | Serial clock bit from the control register |
| sdi_i | input | 1 | Host data bit from the control register |
| sec_i | input | 6 | Seconds counter, 0 to 59 |
| min_i | input | 6 | Minutes counter, 0 to 59 |
| hour_i | input | 5 | Hours counter, 0 to 23 |
| mday_i | input | 5 | Day of month, 1 to 31 |
| mon_i | input | 4 | Month, 1 to 12 |
| year_i | input | 7 | Two-digit year, 0 to 99 |
| sdo_o | output | 1 | Slave data bit, 0 when not driving |
| sdo_en_o | output | 1 | Slave is driving the data bit |
| data_view_o | output | 1 | Data bit as software reads it back |
| irq_clear_o | output | 1 | One-cycle pulse clearing the external interrupt-status bit |

## Verification
The block registers each falling edge at the first clock that sees the serial clock low. The edge count, the drive enable and the bit shown on the data line therefore change one clock after the host lowers the clock. A committed write is visible to a read that starts in any later cycle. The clear pulse is high only during the clock that follows the edge that detected the 16th fall.

The bench changes inputs on falling clock edges. It samples the outputs at the following falling edge, which is after the rising edge that consumed them. A behavioural model advances on the same rising edges, and the bench compares it with every output two time units after each falling edge, once the inputs have settled.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int CMD_W      = 8;
    localparam int FRAME_BITS = 16;
    localparam int PHASE_W    = $clog2(FRAME_BITS + 1);

    localparam logic [PHASE_W-1:0] PH_CMD_DONE = PHASE_W'(CMD_W);
    localparam logic [PHASE_W-1:0] PH_LAST     = PHASE_W'(FRAME_BITS - 1);
    localparam logic [PHASE_W-1:0] PH_FULL     = PHASE_W'(FRAME_BITS);

    localparam int OP_TIME_LO   = 'h20;
    localparam int OP_TIME_HI   = 'h2F;
    localparam int OP_STAT_RD   = 'h30;
    localparam int OP_ZERO_RD   = 'h31;
    localparam int OP_RAM_WR    = 'h80;
    localparam int OP_STAT_WR   = 'hB1;

    localparam logic [7:0] STAT_FLAG_MASK = 8'h18;
    localparam int         STAT_KEY_BIT   = 2;

    typedef enum logic [2:0] {
        CL_RAM_RD,
        CL_TIME_RD,
        CL_STAT_RD,
        CL_ZERO_RD,
        CL_RAM_WR,
        CL_STAT_WR,
        CL_NONE
    } cmd_class_e;

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic [CMD_W-1:0]   cmd;
        logic [7:0]         data;
    } frame_t;

    function automatic logic [7:0] to_bcd(input logic [6:0] v);
        int tens;
        int units;
        tens  = int'(v) / 10;
        units = int'(v) % 10;
        return 8'((tens << 4) | units);
    endfunction

    function automatic cmd_class_e classify(input logic [7:0] c, input int ram_words);
        int ci;
        ci = int'(c);
        if (ci < ram_words)                             return CL_RAM_RD;
        if (ci >= OP_TIME_LO && ci <= OP_TIME_HI)       return CL_TIME_RD;
        if (ci == OP_STAT_RD)                           return CL_STAT_RD;
        if (ci == OP_ZERO_RD)                           return CL_ZERO_RD;
        if (ci >= OP_RAM_WR && ci < OP_RAM_WR + ram_words) return CL_RAM_WR;
        if (ci == OP_STAT_WR)                           return CL_STAT_WR;
        return CL_NONE;
    endfunction

endpackage

// File: rtl/rtc_frame_shift.sv
module rtc_frame_shift
    import rtc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ce_i,
    input  logic   sclk_i,
    input  logic   sdi_i,
    output frame_t frame_o,
    output logic   commit_o,
    output logic [7:0] commit_data_o
);

    logic   sclk_q;
    frame_t fr;
    logic   fall;
    logic   take;

    assign fall          = ce_i && sclk_q && !sclk_i;
    assign take          = fall && (fr.phase != PH_FULL);
    assign commit_data_o = {fr.data[6:0], sdi_i};
    assign commit_o      = take && (fr.phase == PH_LAST);
    assign frame_o       = fr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            fr     <= '0;
        end else begin
            sclk_q <= sclk_i;
            if (!ce_i) begin
                fr <= '0;
            end else if (take) begin
                if (fr.phase < PH_CMD_DONE) begin
                    fr.cmd <= {fr.cmd[CMD_W-2:0], sdi_i};
                end else begin
                    fr.data <= commit_data_o;
                end
                fr.phase <= fr.phase + 1'b1;
            end
        end
    end

    // R3: a low select empties the frame at the next edge
    a_r3_abort_clears: assert property (@(posedge clk) disable iff (rst)
        !ce_i |=> (fr == '0));

    // R2: without a falling serial clock nothing moves
    a_r2_hold_without_fall: assert property (@(posedge clk) disable iff (rst)
        (ce_i && !(sclk_q && !sclk_i)) |=> $stable(fr));

    // R9: a full frame stays full while selected
    a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
        (ce_i && fr.phase == PH_FULL) |=> (fr.phase == PH_FULL));

endmodule

// File: rtl/rtc_store.sv
module rtc_store
    import rtc_pkg::*;
#(
    parameter int         RAM_WORDS   = 32,
    parameter logic [7:0] STATUS_INIT = 8'h90
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] cmd_i,
    input  logic       commit_i,
    input  logic [7:0] wdata_i,
    input  logic [5:0] sec_i,
    input  logic [5:0] min_i,
    input  logic [4:0] hour_i,
    input  logic [4:0] mday_i,
    input  logic [3:0] mon_i,
    input  logic [6:0] year_i,
    output logic [7:0] rd_byte_o,
    output logic       is_read_o,
    output logic       irq_clear_o
);

    localparam int AW = (RAM_WORDS > 1) ? $clog2(RAM_WORDS) : 1;

    logic [7:0]    mem [RAM_WORDS];
    logic [7:0]    status;
    logic          irq_q;
    cmd_class_e    cls;
    logic [AW-1:0] wr_idx;
    logic [AW-1:0] rd_idx;
    logic [7:0]    time_byte;
    logic          key_hit;

    assign cls     = classify(cmd_i, RAM_WORDS);
    assign wr_idx  = AW'(cmd_i - 8'(OP_RAM_WR));
    assign rd_idx  = AW'(cmd_i);
    assign key_hit = commit_i && (cls == CL_STAT_WR) && wdata_i[STAT_KEY_BIT];

    always_comb begin
        case (cmd_i[3:0])
            4'h0:    time_byte = to_bcd({1'b0, sec_i});
            4'h1:    time_byte = to_bcd({1'b0, min_i});
            4'h2:    time_byte = to_bcd({2'b0, hour_i});
            4'h4:    time_byte = to_bcd({2'b0, mday_i});
            4'h5:    time_byte = to_bcd({3'b0, mon_i});
            4'h6:    time_byte = to_bcd(year_i);
            default: time_byte = 8'h00;
        endcase
    end

    always_comb begin
        case (cls)
            CL_RAM_RD:  rd_byte_o = mem[rd_idx];
            CL_TIME_RD: rd_byte_o = time_byte;
            CL_STAT_RD: rd_byte_o = status;
            default:    rd_byte_o = 8'h00;
        endcase
    end

    assign is_read_o   = (cls == CL_RAM_RD) || (cls == CL_TIME_RD) ||
                         (cls == CL_STAT_RD) || (cls == CL_ZERO_RD);
    assign irq_clear_o = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RAM_WORDS; i++) mem[i] <= '0;
            status <= STATUS_INIT;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= key_hit;
            if (key_hit) status <= status & ~STAT_FLAG_MASK;
            if (commit_i && cls == CL_RAM_WR) mem[wr_idx] <= wdata_i;
        end
    end

    // R8: status moves only at a frame commit
    a_r8_status_only_on_commit: assert property (@(posedge clk) disable iff (rst)
        !commit_i |=> $stable(status));

    // R8: the clear pulse lasts a single cycle
    a_r8_pulse_single: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);

endmodule

// File: rtl/serial_rtc_slave.sv
module serial_rtc_slave
    import rtc_pkg::*;
#(
    parameter int         RAM_WORDS   = 32,
    parameter logic [7:0] STATUS_INIT = 8'h90
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_i,
    input  logic       sclk_i,
    input  logic       sdi_i,
    input  logic [5:0] sec_i,
    input  logic [5:0] min_i,
    input  logic [4:0] hour_i,
    input  logic [4:0] mday_i,
    input  logic [3:0] mon_i,
    input  logic [6:0] year_i,
    output logic       sdo_o,
    output logic       sdo_en_o,
    output logic       data_view_o,
    output logic       irq_clear_o
);

    frame_t     fr;
    logic       commit;
    logic [7:0] commit_data;
    logic [7:0] rd_byte;
    logic       is_read;
    logic       in_window;

    rtc_frame_shift u_shift (
        .clk          (clk),
        .rst          (rst),
        .ce_i         (ce_i),
        .sclk_i       (sclk_i),
        .sdi_i        (sdi_i),
        .frame_o      (fr),
        .commit_o     (commit),
        .commit_data_o(commit_data)
    );

    rtc_store #(
        .RAM_WORDS  (RAM_WORDS),
        .STATUS_INIT(STATUS_INIT)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .cmd_i      (fr.cmd),
        .commit_i   (commit),
        .wdata_i    (commit_data),
        .sec_i      (sec_i),
        .min_i      (min_i),
        .hour_i     (hour_i),
        .mday_i     (mday_i),
        .mon_i      (mon_i),
        .year_i     (year_i),
        .rd_byte_o  (rd_byte),
        .is_read_o  (is_read),
        .irq_clear_o(irq_clear_o)
    );

    assign in_window   = (fr.phase >= PH_CMD_DONE) && (fr.phase < PH_FULL);
    assign sdo_en_o    = ce_i && in_window && is_read;
    assign sdo_o       = sdo_en_o ? rd_byte[3'd7 - fr.phase[2:0]] : 1'b0;
    assign data_view_o = sdo_en_o ? sdo_o : sdi_i;

    // R5: a commit always closes the frame
    a_r5_commit_fills_frame: assert property (@(posedge clk) disable iff (rst)
        commit |=> (fr.phase == PH_FULL));

    // R4: no driving while the command is still arriving
    a_r4_quiet_before_data: assert property (@(posedge clk) disable iff (rst)
        (fr.phase < PH_CMD_DONE) |-> !sdo_en_o);

endmodule

// File: tb/serial_rtc_slave_test.sv
module serial_rtc_slave_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic [5:0] sec = 6'd59, mnt = 6'd7;
    logic [4:0] hr = 5'd23, mday = 5'd31;
    logic [3:0] mon = 4'd12;
    logic [6:0] yr = 7'd99;
    logic sdo, sdo_en, view, irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    serial_rtc_slave uut (
        .clk(clk), .rst(rst), .ce_i(ce), .sclk_i(sclk), .sdi_i(sdi),
        .sec_i(sec), .min_i(mnt), .hour_i(hr), .mday_i(mday), .mon_i(mon), .year_i(yr),
        .sdo_o(sdo), .sdo_en_o(sdo_en), .data_view_o(view), .irq_clear_o(irq)
    );

    // behavioural reference model
    int         m_phase;
    logic [7:0] m_cmd, m_data, m_stat;
    logic       m_sq, m_irq;
    logic [7:0] m_ram [32];

    function automatic logic [7:0] bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic logic [7:0] exp_byte(input logic [7:0] c);
        if (c < 8'h20) return m_ram[c[4:0]];
        case (c)
            8'h20: return bcd(int'(sec));
            8'h21: return bcd(int'(mnt));
            8'h22: return bcd(int'(hr));
            8'h24: return bcd(int'(mday));
            8'h25: return bcd(int'(mon));
            8'h26: return bcd(int'(yr));
            8'h30: return m_stat;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_cmd = 0; m_data = 0; m_sq = 0; m_irq = 0; m_stat = 8'h90;
            for (int i = 0; i < 32; i++) m_ram[i] = 8'h00;
        end else begin
            m_irq = 1'b0;
            if (!ce) begin
                m_phase = 0; m_cmd = 0; m_data = 0;
            end else if (m_sq && !sclk && m_phase < 16) begin
                if (m_phase < 8) m_cmd = {m_cmd[6:0], sdi};
                else m_data = {m_data[6:0], sdi};
                m_phase++;
                if (m_phase == 16) begin
                    if (m_cmd >= 8'h80 && m_cmd <= 8'h9F) m_ram[m_cmd[4:0]] = m_data;
                    if (m_cmd == 8'hB1 && m_data[2]) begin
                        m_stat = m_stat & 8'hE7;
                        m_irq  = 1'b1;
                    end
                end
            end
            m_sq = sclk;
        end
    end

    always @(negedge clk) begin
        #2;
        if (!rst) begin
            logic e_drv, e_sdo, e_view;
            e_drv  = ce && m_phase >= 8 && m_phase < 16 && m_cmd <= 8'h31;
            e_sdo  = e_drv ? exp_byte(m_cmd)[15 - m_phase] : 1'b0;
            e_view = e_drv ? e_sdo : sdi;
            checks++;
            if (sdo_en !== e_drv || sdo !== e_sdo) begin
                errors++;
                $display("FAIL R4 cycle model: actual en=%b bit=%b expected en=%b bit=%b",
                         sdo_en, sdo, e_drv, e_sdo);
            end else if (view !== e_view) begin
                errors++;
                $display("FAIL R10 cycle model: actual view=%b expected %b", view, e_view);
            end else if (irq !== m_irq) begin
                errors++;
                $display("FAIL R8 cycle model: actual pulse=%b expected %b", irq, m_irq);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    logic [7:0] got;
    int drv_cnt, view_bad, early_drv, late_bad;
    logic irq_seen, irq_after;

    task automatic xfer(input logic [7:0] c, input logic [7:0] d, input int n);
        logic [15:0] frame;
        frame = {c, d};
        got = 0; drv_cnt = 0; view_bad = 0; early_drv = 0; late_bad = 0;
        @(negedge clk); ce = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sdi  = (i < 16) ? frame[15 - i] : i[0];
            sclk = 1'b1;
            @(negedge clk);
            if (i < 8 && sdo_en) early_drv++;
            if (i >= 8 && i < 16) begin
                got[15 - i] = sdo;
                if (sdo_en) drv_cnt++;
                if (view !== sdo) view_bad++;
            end
            if (i >= 16 && (sdo_en || view !== sdi)) late_bad++;
            sclk = 1'b0;
        end
        @(negedge clk); irq_seen = irq;
        ce = 1'b0; sdi = 1'b0;
        @(negedge clk); irq_after = irq;
    endtask

    task automatic rd(input logic [7:0] c, input string req, input logic [7:0] exp);
        xfer(c, 8'h00, 16);
        chk(req, int'(got), int'(exp));
        chk(req, drv_cnt, 8);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 drive at reset", int'(sdo_en), 0);
        chk("R1 pulse at reset", int'(irq), 0);
        rst = 1'b0;
        @(negedge clk);

        rd(8'h30, "R1 R6 status reset", 8'h90);
        rd(8'h03, "R1 memory reset", 8'h00);
        chk("R4 no drive in command phases", early_drv, 0);
        chk("R10 view matches slave bit", view_bad, 0);

        xfer(8'h83, 8'hA5, 16);
        chk("R11 write does not drive", drv_cnt, 0);
        rd(8'h03, "R5 R4 write then read", 8'hA5);
        xfer(8'h9F, 8'h3C, 16);
        rd(8'h1F, "R5 top address", 8'h3C);
        rd(8'h00, "R5 untouched byte", 8'h00);

        rd(8'h31, "R6 zero status", 8'h00);

        rd(8'h20, "R7 seconds", 8'h59);
        rd(8'h21, "R7 minutes", 8'h07);
        rd(8'h22, "R7 hours", 8'h23);
        rd(8'h24, "R7 day", 8'h31);
        rd(8'h25, "R7 month", 8'h12);
        rd(8'h26, "R7 year", 8'h99);
        rd(8'h23, "R7 unused 0x23", 8'h00);
        rd(8'h2F, "R7 unused 0x2F", 8'h00);
        sec = 6'd0; mnt = 6'd45; hr = 5'd9; mday = 5'd1; mon = 4'd1; yr = 7'd0;
        rd(8'h21, "R7 minutes 45", 8'h45);
        rd(8'h22, "R7 hours 9", 8'h09);
        rd(8'h26, "R7 year 0", 8'h00);

        xfer(8'h85, 8'hFF, 12);
        rd(8'h05, "R3 abandoned write", 8'h00);

        for (int k = 0; k < 5; k++) begin
            @(negedge clk); sclk = 1'b1; sdi = 1'b1;
            @(negedge clk); sclk = 1'b0;
        end
        rd(8'h03, "R2 edges with select low", 8'hA5);

        xfer(8'hB1, 8'h00, 16);
        chk("R8 no key no pulse", int'(irq_seen), 0);
        rd(8'h30, "R8 no key status", 8'h90);
        xfer(8'hB1, 8'h04, 16);
        chk("R8 pulse high", int'(irq_seen), 1);
        chk("R8 pulse one cycle", int'(irq_after), 0);
        rd(8'h30, "R8 flags cleared", 8'h80);

        xfer(8'h40, 8'hFF, 16);
        chk("R11 unknown command no drive", drv_cnt, 0);
        xfer(8'hA0, 8'hFF, 16);
        rd(8'h00, "R11 out of range write", 8'h00);

        xfer(8'h03, 8'h00, 20);
        chk("R9 read value", int'(got), 8'hA5);
        chk("R9 edges after 16 ignored", late_bad, 0);
        xfer(8'h84, 8'h5A, 20);
        rd(8'h04, "R9 write with extra edges", 8'h5A);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule